// File: doc/BRIEF.md
# Data Memory Decoder with Pointer Windows

This block is the data memory front end of a small 8-bit controller core. Every byte address is sorted into one class: pointer window, pointer register, accumulator, flag register, unimplemented location or general-purpose RAM. The block then either serves the access or quietly discards it. It holds the 192-byte scratch RAM, the two pointer registers, the accumulator and the four writable flag bits. All other registers in the low address range belong to other units, so here they read as zero and ignore writes.

Two addresses own no storage. They act as windows: an access there is forwarded to whatever byte the matching pointer names. Reads are combinational from the address. Writes take effect on the rising clock edge.

The read port and the write port each carry their own address, so a move instruction presents both at once. When both addresses fall on windows, the block raises an illegal flag and performs no write.

Top module: `regfile_window`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets both pointers, the accumulator and the flag bits to 00H.
- R2: Pointer 0 lives at 01H and pointer 1 at 03H. Both read and write all 8 bits, and their current values are always visible on ptr0_tap and ptr1_tap.
- R3: The accumulator at 05H reads and writes all 8 bits.
- R4: The flag register at 0AH keeps written bits 3:0. Bits 7:4 always read as 0.
- R5: Addresses 40H to FFH reach the 192-byte RAM. A write is visible on the combinational read path right after the rising edge that commits it.
- R6: An access to 00H is redirected to the address held in pointer 0, and an access to 02H to the address held in pointer 1. The target may be any decoded location, including a pointer, the accumulator or the flag register.
- R7: If the pointer behind a window itself holds 00H or 02H, a read through that window returns 00H and a write through it changes nothing.
- R8: Addresses 04H, 06H to 09H and 0BH to 3FH read 00H and ignore writes.
- R9: When we is high and both rd_addr and wr_addr are 00H or 02H, illegal_move is high in that cycle and no storage changes. In every other case illegal_move is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_addr | input | 8 | Read address |
| wr_addr | input | 8 | Write address |
| wdata | input | 8 | Write data |
| we | input | 1 | Write enable |
| rdata | output | 8 | Combinational read data for rd_addr |
| illegal_move | output | 1 | Window-to-window move seen; write suppressed |
| ptr0_tap | output | 8 | Current value of pointer 0 |
| ptr1_tap | output | 8 | Current value of pointer 1 |

## Verification
A corrupted pointer shows up at once on its tap. It also shows up on the first read through its window, which returns a byte from the wrong address. A wrongly decoded or wrongly dropped write stays hidden until that location is read again. The reference model therefore compares rdata, the illegal flag and both taps before every clock edge, so the error is reported on the first read that exposes the stale or altered byte. Long random runs keep the pointers pointing into the register area and at the window addresses, so that chains of redirection and dropped writes are exercised often.

// File: rtl/regfile_window.sv
module regfile_window #(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int RAM_BASE = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wdata,
  input  logic          we,
  output logic [DW-1:0] rdata,
  output logic          illegal_move,
  output logic [DW-1:0] ptr0_tap,
  output logic [DW-1:0] ptr1_tap
);
  localparam int            RAM_WORDS = (1 << AW) - RAM_BASE;
  localparam int            FLAG_W    = 4;
  localparam logic [AW-1:0] A_WIN0    = AW'(0);
  localparam logic [AW-1:0] A_PTR0    = AW'(1);
  localparam logic [AW-1:0] A_WIN1    = AW'(2);
  localparam logic [AW-1:0] A_PTR1    = AW'(3);
  localparam logic [AW-1:0] A_ACC     = AW'(5);
  localparam logic [AW-1:0] A_FLAG    = AW'(10);
  localparam logic [AW-1:0] RAM_LO    = AW'(RAM_BASE);

  logic [DW-1:0]     ptr0, ptr1, acc;
  logic [FLAG_W-1:0] flags;
  logic [DW-1:0]     ram [RAM_WORDS];

  function automatic logic is_win(input logic [AW-1:0] a);
    return (a == A_WIN0) || (a == A_WIN1);
  endfunction

  logic [AW-1:0] rd_eff, wr_eff, rd_idx, wr_idx;
  logic          rd_dead, wr_dead, wr_ok;

  assign rd_eff  = (rd_addr == A_WIN0) ? AW'(ptr0) :
                   (rd_addr == A_WIN1) ? AW'(ptr1) : rd_addr;
  assign wr_eff  = (wr_addr == A_WIN0) ? AW'(ptr0) :
                   (wr_addr == A_WIN1) ? AW'(ptr1) : wr_addr;
  assign rd_dead = is_win(rd_eff);
  assign wr_dead = is_win(wr_eff);
  assign rd_idx  = rd_eff - RAM_LO;
  assign wr_idx  = wr_eff - RAM_LO;

  assign illegal_move = we && is_win(rd_addr) && is_win(wr_addr);
  assign wr_ok        = we && !wr_dead && !illegal_move;

  always_comb begin
    rdata = '0;
    if (!rd_dead) begin
      if (rd_eff >= RAM_LO)       rdata = ram[rd_idx];
      else if (rd_eff == A_PTR0)  rdata = ptr0;
      else if (rd_eff == A_PTR1)  rdata = ptr1;
      else if (rd_eff == A_ACC)   rdata = acc;
      else if (rd_eff == A_FLAG)  rdata = {{(DW-FLAG_W){1'b0}}, flags};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr0  <= '0;
      ptr1  <= '0;
      acc   <= '0;
      flags <= '0;
    end else if (wr_ok) begin
      if (wr_eff == A_PTR0) ptr0  <= wdata;
      if (wr_eff == A_PTR1) ptr1  <= wdata;
      if (wr_eff == A_ACC)  acc   <= wdata;
      if (wr_eff == A_FLAG) flags <= wdata[FLAG_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok && wr_eff >= RAM_LO) ram[wr_idx] <= wdata;
  end

  assign ptr0_tap = ptr0;
  assign ptr1_tap = ptr1;

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (ptr0_tap == '0 && ptr1_tap == '0 && acc == '0 && flags == '0));

  assert_ptr0_write_R2: assert property (@(posedge clk) disable iff (rst)
    (we && wr_addr == A_PTR0 && !illegal_move) |=> ptr0_tap == $past(wdata));

  assert_flag_high_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == A_FLAG) |-> rdata[DW-1:FLAG_W] == '0);

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_addr > A_FLAG && rd_addr < RAM_LO) |-> rdata == '0);

  assert_dead_window_write_R7: assert property (@(posedge clk) disable iff (rst)
    (we && wr_addr == A_WIN0 && is_win(AW'(ptr0)))
      |=> ($stable(ptr0) && $stable(ptr1) && $stable(acc) && $stable(flags)));

  assert_illegal_no_change_R9: assert property (@(posedge clk) disable iff (rst)
    illegal_move |=> ($stable(ptr0) && $stable(ptr1) && $stable(acc) && $stable(flags)));

  assert_illegal_needs_we_R9: assert property (@(posedge clk) disable iff (rst)
    !we |-> !illegal_move);
endmodule

// File: tb/regfile_window_test.sv
module regfile_window_test;
  logic       clk = 0, rst = 1, we = 0;
  logic [7:0] rd_addr = 0, wr_addr = 0, wdata = 0;
  logic [7:0] rdata, ptr0_tap, ptr1_tap;
  logic       illegal_move;

  int checks = 0, errors = 0;
  int m_p0, m_p1, m_acc, m_flag;
  int m_ram [256];

  regfile_window uut (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .wr_addr(wr_addr),
    .wdata(wdata), .we(we), .rdata(rdata), .illegal_move(illegal_move),
    .ptr0_tap(ptr0_tap), .ptr1_tap(ptr1_tap)
  );

  always #10 clk = ~clk;

  function automatic int resolve(input int a);
    if (a == 0) return m_p0;
    if (a == 2) return m_p1;
    return a;
  endfunction

  function automatic int m_read(input int a);
    int e = resolve(a);
    if (e == 0 || e == 2) return 0;
    if (e == 1) return m_p0;
    if (e == 3) return m_p1;
    if (e == 5) return m_acc;
    if (e == 10) return m_flag;
    if (e >= 64) return m_ram[e];
    return 0;
  endfunction

  function automatic bit m_illegal(input int ra, input int wa, input bit w);
    return w && (ra == 0 || ra == 2) && (wa == 0 || wa == 2);
  endfunction

  task automatic m_write(input int wa, input int wd);
    int e = resolve(wa);
    if (e == 1) m_p0 = wd;
    else if (e == 3) m_p1 = wd;
    else if (e == 5) m_acc = wd;
    else if (e == 10) m_flag = wd & 15;
    else if (e >= 64) m_ram[e] = wd;
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic step(input int ra, input int wa, input int wd, input bit w, input string tag);
    bit ill;
    @(negedge clk);
    rd_addr = 8'(ra); wr_addr = 8'(wa); wdata = 8'(wd); we = w;
    #5;
    ill = m_illegal(ra, wa, w);
    check(tag, "rdata", int'(rdata), m_read(ra));
    check("R9", "illegal_move", int'(illegal_move), int'(ill));
    check("R2", "ptr0_tap", int'(ptr0_tap), m_p0);
    check("R2", "ptr1_tap", int'(ptr1_tap), m_p1);
    if (w && !ill) m_write(wa, wd);
  endtask

  function automatic int pick_addr();
    int r = $urandom_range(0, 9);
    if (r < 4) return $urandom_range(0, 3);
    if (r == 4) return 5;
    if (r == 5) return 10;
    if (r == 6) return $urandom_range(4, 63);
    return $urandom_range(64, 255);
  endfunction

  function automatic int pick_data();
    if ($urandom_range(0, 2) == 0) return $urandom_range(0, 11);
    return $urandom_range(0, 255);
  endfunction

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_p0 = 0; m_p1 = 0; m_acc = 0; m_flag = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    step(1, 0, 0, 0, "R1");
    step(3, 0, 0, 0, "R1");
    step(5, 0, 0, 0, "R1");
    step(10, 0, 0, 0, "R1");
    // R5: preload RAM directly
    for (int a = 64; a < 256; a++) step(a - 1 < 64 ? 5 : a - 1, a, (a * 37) & 255, 1, "R5");
    step(255, 64, 8'h11, 1, "R5");
    step(64, 1, 8'h50, 1, "R5");
    // R2 / R3
    step(1, 3, 8'h05, 1, "R2");
    step(3, 5, 8'hC3, 1, "R2");
    step(5, 0, 0, 0, "R3");
    // R6: windows to RAM and to registers
    step(0, 0, 8'hAA, 1, "R6");
    step(0, 2, 8'h7E, 1, "R6");
    step(5, 0, 0, 0, "R6");
    step(2, 0, 0, 0, "R6");
    // R4
    step(10, 10, 8'hFF, 1, "R4");
    step(10, 0, 0, 0, "R4");
    // R7: pointer aimed at a window
    step(1, 1, 8'h02, 1, "R7");
    step(0, 0, 8'h99, 1, "R7");
    step(0, 0, 0, 0, "R7");
    step(5, 0, 0, 0, "R7");
    // R8
    step(4, 4, 8'h5A, 1, "R8");
    step(4, 32, 8'h5A, 1, "R8");
    step(32, 63, 8'h5A, 1, "R8");
    step(63, 9, 8'h5A, 1, "R8");
    step(9, 0, 0, 0, "R8");
    // R9
    step(0, 2, 8'h44, 1, "R9");
    step(2, 2, 8'h44, 1, "R9");
    step(0, 0, 0, 0, "R9");
    // random mix
    for (int i = 0; i < 3000; i++)
      step(pick_addr(), pick_addr(), pick_data(), $urandom_range(0, 2) != 0, "R6");
    // R1 again after activity
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    m_p0 = 0; m_p1 = 0; m_acc = 0; m_flag = 0;
    step(1, 0, 0, 0, "R1");
    step(5, 0, 0, 0, "R1");
    step(10, 0, 0, 0, "R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule